// File: doc/BRIEF.md
# Eight-Bank Static Memory Chip-Select Controller

This block sits between a CPU-side request port and an external static memory bus. It maps a 28-bit address onto eight banks of 32 MB. Each bank has its own active-low chip select, its own data width (8, 16 or 32 bits) and its own access length. Banks 0 to 6 start at fixed multiples of 32 MB and have a power-of-two size that software can shrink. Bank 7 has a base and a size that can both be programmed. Its window takes priority over any fixed bank that it overlaps.

A word access to a narrow bank runs as several back-to-back bus beats with rising addresses, and the read bytes are assembled in little-endian order. Every beat holds its strobes for a programmed minimum number of cycles. After that minimum, an active-low wait input can stretch the beat. The width of bank 0 is not taken from configuration. It comes from two mode pins sampled just after reset. Between accesses, another bus master can take the bus with an active-low request and acknowledge pair. While it holds the bus, all bus outputs are flagged as released.

Top module: `smc_top`

## Requirements
- R1: For addresses outside the bank 7 window, bits [27:25] select the bank (0 to 6). The chip select of that bank goes low, and bits [24:0] of the address, word aligned, appear on `mem_addr_o`.
- R2: A fixed bank with size code c (3 bits) spans 32 MB >> c from its base. An address above that span, inside the 32 MB slot, hits no bank.
- R3: Bank 7 covers the window from {`cfg_prog_base_i`, 18'b0} with length 32 MB >> its size code. The window beats any fixed bank it overlaps. `mem_addr_o` carries the offset from that base. An address in slot 7 outside the window hits no bank.
- R4: An access that hits no bank drives no chip select. It finishes with `rdy_o` in the cycle after acceptance and returns read data 0.
- R5: Width codes are 00 = 8-bit, 01 = 16-bit, and 10 or 11 = 32-bit. A word access runs 4, 2 or 1 beats. Beat k uses the address base + k × bytes-per-beat and bus lanes starting at lane 0. Read data byte j is taken from beat j / bytes-per-beat, lane j mod bytes-per-beat.
- R6: The width of bank 0 comes from `boot_width_i`, sampled at the first clock after reset is released, using the R5 codes. It stays fixed until the next reset. `cfg_width_i` holds 2 bits for each of banks 1 to 7, with bank 1 in the lowest bits.
- R7: Each beat keeps its chip select low for (access code + 1) cycles when wait is high. The access code is 4 bits per bank in `cfg_acc_i`, with bank 0 in the lowest bits.
- R8: `mem_wait_ni` is looked at only in the last minimum cycle of a beat and after it. While it is low from then on, the beat holds with a stable address. A low wait seen earlier in the beat does not lengthen it.
- R9: `mem_oe_no` is low during the beats of a read and `mem_we_no` is low during the beats of a write, never both at once. `mem_be_no` is low on a lane only during a write beat whose byte is enabled in `be_i`, and stays all high on reads.
- R10: At most one chip select is low at any time, and only during an access beat. Right after reset, all are high.
- R11: The bus is granted only from idle, never in the middle of an access. When `hold_req_ni` is low in idle, it wins over a pending request. `hold_ack_no` then goes low and `bus_drive_o` goes low.
- R12: At the first clock edge that samples `hold_req_ni` high, `hold_ack_no` returns high. `bus_drive_o` returns high one cycle later.
- R13: `rdy_o` is a one-cycle pulse. The requester drops `req_i` in the cycle in which it sees `rdy_o`. No access is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_width_i | input | 2 | Mode pins that set the width of bank 0 |
| cfg_width_i | input | 14 | Width codes for banks 1 to 7 |
| cfg_acc_i | input | 32 | Access-length codes, 4 bits per bank |
| cfg_size_i | input | 24 | Size codes, 3 bits per bank |
| cfg_prog_base_i | input | 10 | Bank 7 base address bits [27:18] |
| req_i | input | 1 | Access request, held until rdy_o |
| we_i | input | 1 | 1 = write |
| addr_i | input | 28 | Byte address |
| be_i | input | 4 | Byte enables of the word |
| wdata_i | input | 32 | Write data |
| rdy_o | output | 1 | Access finished |
| rdata_o | output | 32 | Assembled read data |
| mem_addr_o | output | 25 | Address within the bank |
| mem_cs_no | output | 8 | Chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_be_no | output | 4 | Lane byte enables, active low |
| mem_wdata_o | output | 32 | Bus write data |
| mem_wdata_oe_o | output | 1 | Bus data drive enable |
| mem_rdata_i | input | 32 | Bus read data |
| mem_wait_ni | input | 1 | Wait, active low |
| bus_drive_o | output | 1 | 1 = address and control outputs driven |
| hold_req_ni | input | 1 | Bus request from another master |
| hold_ack_no | output | 1 | Bus grant |

## Verification
The bench covers three kinds of corner case.

**Decode.** It probes the address where the bank 7 window overlaps bank 0 and the byte just past that window. It also probes the last word of a bank whose size has been reduced and the first word beyond it, and a slot 7 address outside the window. A decoder with the wrong priority or a mis-sized mask would raise the wrong chip select, or any chip select at all where none belongs.

**Width and wait.** It reads narrow banks and compares every assembled byte. A wrong lane or byte order would scramble rdata_o. It also counts strobe cycles with wait held low for a short time and for a long time. A design that sampled wait too early would stretch the first case, and one that ignored wait would shorten the second.

**Bus handover.** It raises a bus request during an access and while an access is pending. A grant in the middle of an access, or a request that beat the grant, would show on hold_ack_no and on the chip selects. The bench also reruns bank 0 after resets with other mode-pin values, to expose a bank 0 width taken from the wrong source.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD, ST_RESUME} smc_state_e;

  // log2 of bytes per beat for a width code
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/smc_decode.sv
module smc_decode #(
  parameter int ADDR_W   = 28,
  parameter int BANK_AW  = 25,
  parameter int SIZE_W   = 3,
  parameter int BASE_LSB = 18,
  localparam int BANK_W  = ADDR_W - BANK_AW,
  localparam int NBANK   = 1 << BANK_W
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NBANK*SIZE_W-1:0]    cfg_size_i,
  input  logic [ADDR_W-BASE_LSB-1:0] prog_base_i,
  output logic                       hit_o,
  output logic [BANK_W-1:0]          bank_o,
  output logic [BANK_AW-1:0]         off_o
);
  logic [ADDR_W-1:0] prog_base, diff;
  logic [SIZE_W-1:0] prog_sz, slot_sz;
  logic [BANK_W-1:0] slot;
  logic              prog_hit, slot_hit;

  assign prog_base = {prog_base_i, {BASE_LSB{1'b0}}};
  assign diff      = addr_i - prog_base;
  assign prog_sz   = cfg_size_i[(NBANK-1)*SIZE_W +: SIZE_W];
  assign prog_hit  = (diff >> (BANK_AW - int'(prog_sz))) == '0;

  assign slot      = addr_i[ADDR_W-1 -: BANK_W];
  assign slot_sz   = cfg_size_i[int'(slot)*SIZE_W +: SIZE_W];
  // top slot is reserved for the movable bank
  assign slot_hit  = (slot != BANK_W'(NBANK-1)) &&
                     ((addr_i[BANK_AW-1:0] >> (BANK_AW - int'(slot_sz))) == '0);

  assign hit_o  = prog_hit | slot_hit;
  assign bank_o = prog_hit ? BANK_W'(NBANK-1) : slot;
  assign off_o  = prog_hit ? diff[BANK_AW-1:0] : addr_i[BANK_AW-1:0];
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int BANK_AW = 25,
  parameter int BANK_W  = 3,
  parameter int ACC_W   = 4,
  parameter int DATA_W  = 32,
  localparam int NBANK  = 1 << BANK_W,
  localparam int NLANE  = DATA_W / 8,
  localparam int LANE_W = $clog2(NLANE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [NLANE-1:0]   be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               hit_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [BANK_AW-1:0] off_i,
  input  logic [1:0]         width_i,
  input  logic [ACC_W-1:0]   acc_i,
  output logic               rdy_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [BANK_AW-1:0] mem_addr_o,
  output logic [NBANK-1:0]   mem_cs_no,
  output logic               mem_oe_no,
  output logic               mem_we_no,
  output logic [NLANE-1:0]   mem_be_no,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_wdata_oe_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               mem_wait_ni,
  output logic               bus_drive_o,
  input  logic               hold_req_ni,
  output logic               hold_ack_no
);
  smc_state_e         state_q;
  logic [LANE_W-1:0]  beat_q, byte_base, last_beat;
  logic [1:0]         wsh_q;
  logic [ACC_W-1:0]   cnt_q, acc_q;
  logic [BANK_W-1:0]  bank_q;
  logic [BANK_AW-1:0] off_q;
  logic               we_q, rdy_q;
  logic [NLANE-1:0]   be_q, lane_ben;
  logic [DATA_W-1:0]  wdata_q, rdata_q, rdata_next, lane_wdata;
  logic               strobe, beat_end;
  int                 nbytes;

  assign nbytes    = 1 << wsh_q;
  assign byte_base = LANE_W'(beat_q << wsh_q);
  assign last_beat = LANE_W'((NLANE >> wsh_q) - 1);
  assign strobe    = state_q == ST_STROBE;
  assign beat_end  = strobe && cnt_q == '0 && mem_wait_ni;

  always_comb begin
    int lane;
    rdata_next = rdata_q;
    for (int j = 0; j < NLANE; j++) begin
      lane = j - int'(byte_base);
      if (lane >= 0 && lane < nbytes) rdata_next[8*j +: 8] = mem_rdata_i[8*lane +: 8];
    end
  end

  always_comb begin
    int src;
    lane_wdata = '0;
    lane_ben   = '1;
    for (int k = 0; k < NLANE; k++) begin
      src = (int'(byte_base) + k) % NLANE;
      if (k < nbytes) begin
        lane_wdata[8*k +: 8] = wdata_q[8*src +: 8];
        lane_ben[k]          = ~be_q[src];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wsh_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      bank_q  <= '0;
      off_q   <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!hold_req_ni) begin
            state_q <= ST_HOLD;
          end else if (req_i && !rdy_q) begin
            if (hit_i) begin
              state_q <= ST_STROBE;
              beat_q  <= '0;
              wsh_q   <= width_shift(width_i);
              cnt_q   <= acc_i;
              acc_q   <= acc_i;
              bank_q  <= bank_i;
              off_q   <= off_i & ~BANK_AW'(NLANE-1);
              we_q    <= we_i;
              be_q    <= be_i;
              wdata_q <= wdata_i;
            end else begin
              rdy_q   <= 1'b1;
              rdata_q <= '0;
            end
          end
        end
        ST_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (mem_wait_ni) begin
            rdata_q <= rdata_next;
            if (beat_q == last_beat) begin
              state_q <= ST_IDLE;
              rdy_q   <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
              cnt_q  <= acc_q;
            end
          end
        end
        ST_HOLD:   if (hold_req_ni) state_q <= ST_RESUME;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o          = rdy_q;
  assign rdata_o        = rdata_q;
  assign mem_addr_o     = off_q | BANK_AW'(byte_base);
  assign mem_cs_no      = strobe ? ~(NBANK'(1) << bank_q) : '1;
  assign mem_oe_no      = ~(strobe && !we_q);
  assign mem_we_no      = ~(strobe && we_q);
  assign mem_be_no      = (strobe && we_q) ? lane_ben : '1;
  assign mem_wdata_o    = lane_wdata;
  assign mem_wdata_oe_o = strobe && we_q;
  assign bus_drive_o    = !(state_q == ST_HOLD || state_q == ST_RESUME);
  assign hold_ack_no    = state_q != ST_HOLD;

  // R10
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  // R8
  wait_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && cnt_q == '0 && !mem_wait_ni) |=> (!(&mem_cs_no) && $stable(mem_addr_o)));
  // R11
  grant_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_no) |-> $past(mem_cs_no) == '1);
  // R11
  grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ack_no |-> (!bus_drive_o && mem_cs_no == '1));
  // R12
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ack_no && hold_req_ni) |=> (hold_ack_no && !bus_drive_o));
  // R13
  rdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);
endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int BANK_AW  = 25,
  parameter int ACC_W    = 4,
  parameter int SIZE_W   = 3,
  parameter int BASE_LSB = 18,
  parameter int DATA_W   = 32,
  localparam int BANK_W  = ADDR_W - BANK_AW,
  localparam int NBANK   = 1 << BANK_W,
  localparam int NLANE   = DATA_W / 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 boot_width_i,
  input  logic [(NBANK-1)*2-1:0]     cfg_width_i,
  input  logic [NBANK*ACC_W-1:0]     cfg_acc_i,
  input  logic [NBANK*SIZE_W-1:0]    cfg_size_i,
  input  logic [ADDR_W-BASE_LSB-1:0] cfg_prog_base_i,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NLANE-1:0]           be_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic                       rdy_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [BANK_AW-1:0]         mem_addr_o,
  output logic [NBANK-1:0]           mem_cs_no,
  output logic                       mem_oe_no,
  output logic                       mem_we_no,
  output logic [NLANE-1:0]           mem_be_no,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic                       mem_wdata_oe_o,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  input  logic                       mem_wait_ni,
  output logic                       bus_drive_o,
  input  logic                       hold_req_ni,
  output logic                       hold_ack_no
);
  logic [1:0]         boot_q, sel_w;
  logic               boot_vld_q, dec_hit;
  logic [BANK_W-1:0]  dec_bank;
  logic [BANK_AW-1:0] dec_off;
  logic [ACC_W-1:0]   sel_acc;

  // mode pins captured once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q     <= '0;
      boot_vld_q <= 1'b0;
    end else if (!boot_vld_q) begin
      boot_q     <= boot_width_i;
      boot_vld_q <= 1'b1;
    end
  end

  smc_decode #(
    .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .SIZE_W(SIZE_W), .BASE_LSB(BASE_LSB)
  ) u_dec (
    .addr_i(addr_i), .cfg_size_i(cfg_size_i), .prog_base_i(cfg_prog_base_i),
    .hit_o(dec_hit), .bank_o(dec_bank), .off_o(dec_off)
  );

  always_comb begin
    if (dec_bank == '0) sel_w = boot_q;
    else                sel_w = cfg_width_i[(int'(dec_bank)-1)*2 +: 2];
    sel_acc = cfg_acc_i[int'(dec_bank)*ACC_W +: ACC_W];
  end

  smc_seq #(
    .BANK_AW(BANK_AW), .BANK_W(BANK_W), .ACC_W(ACC_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i & boot_vld_q), .we_i(we_i), .be_i(be_i), .wdata_i(wdata_i),
    .hit_i(dec_hit), .bank_i(dec_bank), .off_i(dec_off),
    .width_i(sel_w), .acc_i(sel_acc),
    .rdy_o(rdy_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_cs_no(mem_cs_no),
    .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no), .mem_be_no(mem_be_no),
    .mem_wdata_o(mem_wdata_o), .mem_wdata_oe_o(mem_wdata_oe_o),
    .mem_rdata_i(mem_rdata_i), .mem_wait_ni(mem_wait_ni),
    .bus_drive_o(bus_drive_o), .hold_req_ni(hold_req_ni), .hold_ack_no(hold_ack_no)
  );

  // R6
  boot_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(boot_vld_q) |-> $stable(boot_q));
endmodule

// File: tb/smc_top_test.sv
module smc_top_test;
  typedef struct packed {
    logic [27:0] addr;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [3:0]  bank;  // 8 = no bank
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{28'h0000100, 1'b0, 4'hF, 32'h0,         4'd0},
    '{28'h2000204, 1'b1, 4'hF, 32'h11223344, 4'd1},
    '{28'h4000008, 1'b0, 4'hF, 32'h0,         4'd2},
    '{28'h6000010, 1'b1, 4'h6, 32'hA1B2C3D4, 4'd3},
    '{28'h6FFFFFC, 1'b0, 4'hF, 32'h0,         4'd3},
    '{28'h7000000, 1'b0, 4'hF, 32'h0,         4'd8},
    '{28'h8000040, 1'b0, 4'hF, 32'h0,         4'd4},
    '{28'hA000000, 1'b1, 4'h9, 32'hDEADBEEF, 4'd5},
    '{28'hC000010, 1'b0, 4'hF, 32'h0,         4'd6},
    '{28'h0400010, 1'b0, 4'hF, 32'h0,         4'd7},
    '{28'h05FFFF0, 1'b1, 4'hF, 32'h55667788, 4'd7},
    '{28'h0600000, 1'b0, 4'hF, 32'h0,         4'd0},
    '{28'hE000000, 1'b0, 4'hF, 32'h0,         4'd8},
    '{28'h03FFFFC, 1'b0, 4'hF, 32'h0,         4'd0}
  };
  localparam logic [27:0] B7BASE = 28'h0400000;
  localparam int BW [8]  = '{0, 0, 2, 1, 0, 2, 3, 1};
  localparam int ACC [8] = '{1, 0, 2, 1, 3, 0, 1, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] boot = 2'b01;
  logic req = 1'b0, we = 1'b0, wait_n = 1'b1, hreq_n = 1'b1;
  logic [27:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, mem_rdata;
  logic rdy, oe_n, we_n, wd_oe, drive, ack_n;
  logic [31:0] rdata, mem_wdata;
  logic [24:0] mem_addr;
  logic [7:0] cs_n;
  logic [3:0] be_n;

  int nchk = 0, nfail = 0, cyc = 0;
  int strobes = 0, wait_len = 0, waited = 0;
  logic [7:0] cs_seen = '0;
  logic [31:0] img = '0;
  logic be_on_read = 1'b0;

  smc_top uut (
    .clk_i(clk), .rst_ni(rst_n), .boot_width_i(boot),
    .cfg_width_i({2'b01, 2'b11, 2'b10, 2'b00, 2'b01, 2'b10, 2'b00}),
    .cfg_acc_i({4'd2, 4'd1, 4'd0, 4'd3, 4'd1, 4'd2, 4'd0, 4'd1}),
    .cfg_size_i({3'd4, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0}),
    .cfg_prog_base_i(10'h010),
    .req_i(req), .we_i(we), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .rdy_o(rdy), .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_cs_no(cs_n),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_be_no(be_n),
    .mem_wdata_o(mem_wdata), .mem_wdata_oe_o(wd_oe), .mem_rdata_i(mem_rdata),
    .mem_wait_ni(wait_n), .bus_drive_o(drive), .hold_req_ni(hreq_n), .hold_ack_no(ack_n)
  );

  always #2500ps clk = ~clk;

  function automatic logic [7:0] mdl(input int bank, input logic [24:0] ma, input int lane);
    return ma[7:0] ^ ma[15:8] ^ 8'(lane * 65) ^ 8'(bank * 23);
  endfunction

  function automatic int wsh_of(input int bank);
    int code;
    code = (bank == 0) ? int'(boot) : BW[bank];
    return (code == 0) ? 0 : (code == 1) ? 1 : 2;
  endfunction

  function automatic int exp_strobes(input int bank);
    return (4 >> wsh_of(bank)) * (ACC[bank] + 1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [27:0] a, input int bank);
    logic [27:0] off;
    logic [31:0] r;
    int nb, bb;
    off = (bank == 7) ? (a - B7BASE) : {3'b0, a[24:0]};
    off = off & ~28'h3;
    nb  = 1 << wsh_of(bank);
    for (int j = 0; j < 4; j++) begin
      bb = j & ~(nb - 1);
      r[8*j +: 8] = mdl(bank, off[24:0] | 25'(bb), j - bb);
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_img(input logic [3:0] b, input logic [31:0] d);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[8*j +: 8] = b[j] ? d[8*j +: 8] : 8'h00;
    return r;
  endfunction

  // memory model: data depends on selected bank, bus address and lane
  always_comb begin
    int bk;
    bk = 0;
    for (int b = 0; b < 8; b++) if (!cs_n[b]) bk = b;
    for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mdl(bk, mem_addr, k);
  end

  // bus monitor and wait driver
  always @(negedge clk) begin
    if (cs_n != 8'hFF) begin
      wait_n <= (strobes < wait_len) ? 1'b0 : 1'b1;
      strobes <= strobes + 1;
      cs_seen <= cs_seen | ~cs_n;
      if (!oe_n && be_n != 4'hF) be_on_read <= 1'b1;
      if (!we_n)
        for (int k = 0; k < 4; k++)
          if (!be_n[k]) img[8*(int'(mem_addr[1:0]) + k) +: 8] <= mem_wdata[8*k +: 8];
    end else begin
      wait_n <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    strobes = 0; cs_seen = '0; img = '0; be_on_read = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] b);
    @(negedge clk);
    rst_n = 1'b0; boot = b; req = 1'b0; hreq_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [27:0] a, input logic w, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    clr_mon();
    addr = a; we = w; be = b; wdata = d; req = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!rdy && waited < 300);
    req = 1'b0;
  endtask

  initial begin
    int bad;
    string tg;
    do_reset(2'b01);
    // reset state
    chk("R10 cs after reset", 32'(cs_n), 32'hFF);
    chk("R11 ack after reset", 32'(ack_n), 32'h1);
    chk("R12 drive after reset", 32'(drive), 32'h1);
    chk("R13 rdy after reset", 32'(rdy), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      run(VECS[i].addr, VECS[i].we, VECS[i].be, VECS[i].wdata);
      if (VECS[i].bank == 4'd8) begin
        // R2 / R3 out-of-range slots land here
        chk("R4 miss cs", 32'(cs_seen), 32'h0);
        chk("R4 miss latency", 32'(waited), 32'd1);
        chk("R4 miss rdata", rdata, 32'h0);
      end else begin
        tg = (VECS[i].bank == 4'd7) ? "R3" : (VECS[i].bank == 4'd3) ? "R2" : "R1";
        chk({tg, " bank select"}, 32'(cs_seen), 32'(8'h1 << VECS[i].bank));
        chk("R7 strobe cycles", 32'(strobes), 32'(exp_strobes(int'(VECS[i].bank))));
        if (VECS[i].we) chk("R9 written lanes", img, exp_img(VECS[i].be, VECS[i].wdata));
        else begin
          chk("R5 read assembly", rdata, exp_read(VECS[i].addr, int'(VECS[i].bank)));
          chk("R9 be on read", 32'(be_on_read), 32'h0);
        end
      end
      @(negedge clk);
      chk("R13 rdy pulse", 32'(rdy), 32'h0);
    end

    // R8 wait low only inside the minimum: no extension
    wait_len = 1;
    run(28'h4000020, 1'b0, 4'hF, 32'h0);
    chk("R8 early wait", 32'(strobes), 32'd3);
    chk("R8 early wait data", rdata, exp_read(28'h4000020, 2));
    // R8 wait low past the minimum: stretched
    wait_len = 5;
    run(28'h4000024, 1'b0, 4'hF, 32'h0);
    chk("R8 late wait", 32'(strobes), 32'd6);
    chk("R8 late wait data", rdata, exp_read(28'h4000024, 2));
    wait_len = 0;

    // R11 hold wins over pending request; R12 release timing
    @(negedge clk);
    clr_mon();
    hreq_n = 1'b0;
    @(negedge clk);
    chk("R11 ack granted", 32'(ack_n), 32'h0);
    chk("R11 bus released", 32'(drive), 32'h0);
    addr = 28'h4000030; we = 1'b0; be = 4'hF; req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 request held off", 32'(cs_seen), 32'h0);
    hreq_n = 1'b1;
    @(negedge clk);
    chk("R12 ack removed", 32'(ack_n), 32'h1);
    chk("R12 still released", 32'(drive), 32'h0);
    @(negedge clk);
    chk("R12 bus driven", 32'(drive), 32'h1);
    waited = 0;
    do begin @(negedge clk); waited++; end while (!rdy && waited < 300);
    req = 1'b0;
    chk("R11 deferred access", rdata, exp_read(28'h4000030, 2));

    // R11 request during an access waits for its end
    @(negedge clk);
    clr_mon();
    addr = 28'h8000000; we = 1'b0; be = 4'hF; req = 1'b1;
    repeat (3) @(negedge clk);
    hreq_n = 1'b0;
    bad = 0;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
      if (!ack_n && !rdy) bad++;
    end while (!rdy && waited < 300);
    req = 1'b0;
    chk("R11 no mid-access grant", 32'(bad), 32'h0);
    chk("R11 access completed", 32'(strobes), 32'd16);
    @(negedge clk);
    chk("R11 grant after access", 32'(ack_n), 32'h0);
    chk("R10 no cs while held", 32'(cs_n), 32'hFF);
    hreq_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 bank 0 width from mode pins
    do_reset(2'b00);
    run(28'h0000100, 1'b0, 4'hF, 32'h0);
    chk("R6 8-bit boot cycles", 32'(strobes), 32'd8);
    chk("R6 8-bit boot data", rdata, exp_read(28'h0000100, 0));
    do_reset(2'b11);
    run(28'h0000100, 1'b0, 4'hF, 32'h0);
    chk("R6 code 11 cycles", 32'(strobes), 32'd2);
    chk("R6 code 11 data", rdata, exp_read(28'h0000100, 0));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule